// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device side of a small serial flash. It works entirely in the system clock domain. SCK, SI and the active-low chip select reach it already synchronised, and it finds SCK edges by comparing each sample with the one before. Every bus cycle is one byte, shifted in MSB first on rising SCK edges, so SPI modes 0 and 3 are both served. The first byte of a frame is an opcode. The bytes that follow are address, dummy, confirm or data bytes, depending on the opcode.

Read data comes from a byte-wide memory port. The block raises a one-cycle strobe with a 17-bit address, and the memory answers on the clock after the strobe. Erase and program work is handed to a separate sequencer as one request, which is held until the sequencer acknowledges it. The sequencer's busy flag is reported in the status byte. The serial output is a data bit plus an output enable. New bits are launched on falling SCK edges. The enable is high only in data-out phases and drops in the same cycle that chip select rises.

The clock is expected to run at least eight times faster than SCK, so each SCK half period spans at least four clocks.

Top module: `sflash_cmd_front`

## Requirements
- R1: After reset, so_oe_o, mem_rd_o and seq_req_o are all low.
- R2: Read is opcode FFh, then three address bytes (most significant first), then one dummy byte. The address bits above bit 16 are ignored. From the next SCK falling edge onward, memory bytes stream out MSB first, starting at the given address. Modes 0 and 3 give the same data.
- R3: During a read, every further byte comes from the next address (one memory strobe per byte). After address 1FFFFh the stream wraps to 00000h and runs on until chip select rises.
- R4: ID read is opcode 90h, then two ignored bytes, then an address byte. If bit 0 of that byte is 0, the byte DAh is returned. If it is 1, the byte 98h is returned. The same byte repeats while SCK runs.
- R5: Status read is opcode 9Fh. It is followed by the status byte for as long as SCK runs. Bit 0 of the status byte is 1 when neither seq_busy_i nor a pending request is present. Bits 7..1 are 0.
- R6: Sector erase is 20h, then two address bytes (A23..A16, A15..A8), then D0h. It raises a request with seq_op_o = 01 and seq_addr_o equal to A16..A12 followed by twelve zero bits.
- R7: Chip erase is 60h, then two ignored bytes, then D0h. It raises a request with seq_op_o = 10 and seq_addr_o = 0.
- R8: Byte program is 10h, then three address bytes, then one data byte. It raises a request with seq_op_o = 11, seq_addr_o set to the 17-bit address and seq_data_o set to the data byte.
- R9: An unknown opcode, or an erase whose fourth byte is not D0h, raises no request and enables no output for the rest of the frame.
- R10: While seq_busy_i is high or a request is pending, every opcode except 9Fh is ignored: no request and no output.
- R11: If chip select rises before the last bit of a command, no request is raised.
- R12: so_oe_o is high only in data-out phases, never during opcode, address, dummy or confirm bytes. It is low in any cycle where cs_n_i is high.
- R13: seq_req_o stays high, with seq_op_o, seq_addr_o and seq_data_o unchanged, until seq_ack_i. It drops on the clock after seq_ack_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Synchronised serial clock |
| si_i | input | 1 | Synchronised serial data in |
| cs_n_i | input | 1 | Synchronised active-low chip select |
| so_o | output | 1 | Serial data out bit |
| so_oe_o | output | 1 | Output enable for so_o |
| mem_rd_o | output | 1 | Read strobe to the memory port |
| mem_addr_o | output | 17 | Byte address for the memory read |
| mem_data_i | input | 8 | Memory data, valid the clock after mem_rd_o |
| seq_req_o | output | 1 | Erase/program request to the sequencer |
| seq_op_o | output | 2 | Request kind: 01 sector erase, 10 chip erase, 11 program |
| seq_addr_o | output | 17 | Request address |
| seq_data_o | output | 8 | Program data |
| seq_ack_i | input | 1 | Sequencer accepts the request |
| seq_busy_i | input | 1 | Sequencer is working |

## Verification
Reads are run in both SPI modes. One starts mid-array with junk in the ignored high address bits, which separates correct masking and MSB-first order from a shifted or offset address. The other starts two bytes below the top of the array, which shows whether the stream wraps to zero. Each erase and program command is sent once well formed and once spoiled (wrong confirm, unknown opcode, early chip-select release, or sequencer busy), so that a request raised by the full frame can be told apart from one raised by a prefix. ID and status reads are run with both select values and both busy states, so that a constant output cannot pass.

// File: rtl/sfc_pkg.sv
// Package: shared constants and types for the serial flash command front end.
// Assumes an 8-bit bus cycle; the opcode and confirm values set the frame format.
package sfc_pkg;

    localparam int IDX_W = 3;

    localparam logic [7:0] OPC_READ   = 8'hFF;
    localparam logic [7:0] OPC_IDENT  = 8'h90;
    localparam logic [7:0] OPC_STATUS = 8'h9F;
    localparam logic [7:0] OPC_SERASE = 8'h20;
    localparam logic [7:0] OPC_CERASE = 8'h60;
    localparam logic [7:0] OPC_PROG   = 8'h10;
    localparam logic [7:0] CONFIRM    = 8'hD0;

    localparam logic [IDX_W-1:0] IX_OPC   = 3'd0;
    localparam logic [IDX_W-1:0] IX_LAST3 = 3'd3;
    localparam logic [IDX_W-1:0] IX_LAST4 = 3'd4;
    localparam logic [IDX_W-1:0] IX_MAX   = 3'd7;

    typedef enum logic [2:0] {
        C_NONE, C_READ, C_IDENT, C_STATUS, C_SERASE, C_CERASE, C_PROG
    } cmd_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_PROG   = 2'b11
    } seq_op_e;

endpackage

// File: rtl/sfc_edge.sv
// Module: detects SCK edges from the synchronised SCK samples.
// Assumes sck_i is already synchronised; edges seen while chip select is high are masked.
module sfc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    output logic rise,
    output logic fall
);
    logic sck_q;

    // Remember the previous SCK sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_i;
    end

    assign rise = sck_i & ~sck_q & ~cs_n_i;
    assign fall = ~sck_i & sck_q & ~cs_n_i;
endmodule

// File: rtl/sfc_rx.sv
// Module: shifts in SI, MSB first, on rising SCK edges and numbers the bytes of a frame.
// Assumes a frame restarts while chip select is high; the byte index saturates at its maximum.
module sfc_rx
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             rise,
    input  logic             si_i,
    output logic             byte_done,
    output logic [7:0]       byte_val,
    output logic [IDX_W-1:0] byte_idx
);
    logic [6:0] sh;
    logic [2:0] bit_cnt;

    assign byte_done = rise & (bit_cnt == 3'd7);
    assign byte_val  = {sh, si_i};

    // Shift bits in and advance the bit and byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_i) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_idx <= IX_OPC;
        end else if (rise) begin
            sh      <= {sh[5:0], si_i};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_idx != IX_MAX)
                byte_idx <= byte_idx + 3'd1;
        end
    end
endmodule

// File: rtl/sfc_tx.sv
// Module: output shifter; loads an armed byte on a falling SCK edge, otherwise shifts left.
// Assumes the byte is armed on a rising edge and its data is settled before the next fall.
module sfc_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       fall,
    input  logic       load_req,
    input  logic [7:0] nxt_byte,
    output logic       so_o,
    output logic       so_oe_o
);
    logic [7:0] sh;
    logic       pend;
    logic       active;

    // Arm, load and shift the output byte; the output phase ends with chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            pend   <= 1'b0;
            active <= 1'b0;
        end else if (cs_n_i) begin
            pend   <= 1'b0;
            active <= 1'b0;
        end else begin
            if (load_req) pend <= 1'b1;
            if (fall) begin
                if (pend) begin
                    sh     <= nxt_byte;
                    pend   <= 1'b0;
                    active <= 1'b1;
                end else begin
                    sh <= {sh[6:0], 1'b0};
                end
            end
        end
    end

    assign so_o    = sh[7];
    assign so_oe_o = active & ~cs_n_i;
endmodule

// File: rtl/sfc_decode.sv
// Module: command decoder; drives the memory read port, the output byte and the sequencer request.
// Assumes the memory answers the clock after mem_rd_o, and that a request is raised only when none is pending.
module sfc_decode
    import sfc_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter int         SECTOR_LOG = 12,
    parameter logic [7:0] MFR_ID     = 8'hDA,
    parameter logic [7:0] DEV_ID     = 8'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              byte_done,
    input  logic [7:0]        byte_val,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        mem_data_i,
    input  logic              seq_ack_i,
    input  logic              seq_busy_i,
    output logic              load_req,
    output logic [7:0]        nxt_byte,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              seq_req_o,
    output logic [1:0]        seq_op_o,
    output logic [ADDR_W-1:0] seq_addr_o,
    output logic [7:0]        seq_data_o
);
    localparam int PAGE_HI = ADDR_W - 9;

    cmd_e              cmd;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_wait;
    logic              ready;
    logic [ADDR_W-1:0] page_a;
    logic [ADDR_W-1:0] sect_a;
    logic              commit;
    seq_op_e           c_op;
    logic [ADDR_W-1:0] c_addr;
    logic [7:0]        c_data;

    assign ready      = ~seq_busy_i & ~seq_req_o;
    assign page_a     = {addr_sh[PAGE_HI:0], 8'h00};
    assign sect_a     = {page_a[ADDR_W-1:SECTOR_LOG], {SECTOR_LOG{1'b0}}};
    assign mem_addr_o = rd_addr;

    // Decide whether the byte just completed finishes an erase or program command.
    always_comb begin
        commit = 1'b0;
        c_op   = OP_IDLE;
        c_addr = '0;
        c_data = '0;
        if (byte_done && !seq_req_o) begin
            unique case (cmd)
                C_SERASE: if (byte_idx == IX_LAST3 && byte_val == CONFIRM) begin
                    commit = 1'b1;
                    c_op   = OP_SERASE;
                    c_addr = sect_a;
                end
                C_CERASE: if (byte_idx == IX_LAST3 && byte_val == CONFIRM) begin
                    commit = 1'b1;
                    c_op   = OP_CERASE;
                end
                C_PROG: if (byte_idx == IX_LAST4) begin
                    commit = 1'b1;
                    c_op   = OP_PROG;
                    c_addr = addr_sh;
                    c_data = byte_val;
                end
                default: ;
            endcase
        end
    end

    // Frame state: decode the opcode, collect the address and arm each output byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_i) begin
            cmd      <= C_NONE;
            addr_sh  <= '0;
            rd_addr  <= '0;
            load_req <= 1'b0;
            mem_rd_o <= 1'b0;
            rd_wait  <= 1'b0;
            nxt_byte <= '0;
        end else begin
            load_req <= 1'b0;
            mem_rd_o <= 1'b0;
            rd_wait  <= mem_rd_o;
            if (rd_wait) nxt_byte <= mem_data_i;
            if (byte_done) begin
                if (byte_idx == IX_OPC) begin
                    if (!ready && byte_val != OPC_STATUS) begin
                        cmd <= C_NONE;
                    end else begin
                        unique case (byte_val)
                            OPC_READ:   cmd <= C_READ;
                            OPC_IDENT:  cmd <= C_IDENT;
                            OPC_SERASE: cmd <= C_SERASE;
                            OPC_CERASE: cmd <= C_CERASE;
                            OPC_PROG:   cmd <= C_PROG;
                            OPC_STATUS: begin
                                cmd      <= C_STATUS;
                                nxt_byte <= {7'b0, ready};
                                load_req <= 1'b1;
                            end
                            default:    cmd <= C_NONE;
                        endcase
                    end
                end else begin
                    addr_sh <= {addr_sh[ADDR_W-9:0], byte_val};
                    unique case (cmd)
                        C_READ: begin
                            if (byte_idx == IX_LAST4) begin
                                rd_addr  <= addr_sh;
                                mem_rd_o <= 1'b1;
                                load_req <= 1'b1;
                            end else if (byte_idx > IX_LAST4) begin
                                rd_addr  <= rd_addr + 1'b1;
                                mem_rd_o <= 1'b1;
                                load_req <= 1'b1;
                            end
                        end
                        C_IDENT: begin
                            if (byte_idx == IX_LAST3) begin
                                nxt_byte <= byte_val[0] ? DEV_ID : MFR_ID;
                                load_req <= 1'b1;
                            end else if (byte_idx > IX_LAST3) begin
                                load_req <= 1'b1;
                            end
                        end
                        C_STATUS: begin
                            nxt_byte <= {7'b0, ready};
                            load_req <= 1'b1;
                        end
                        C_SERASE, C_CERASE: if (byte_idx == IX_LAST3) cmd <= C_NONE;
                        C_PROG:             if (byte_idx == IX_LAST4) cmd <= C_NONE;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Sequencer request: set on a commit, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_req_o  <= 1'b0;
            seq_op_o   <= OP_IDLE;
            seq_addr_o <= '0;
            seq_data_o <= '0;
        end else if (seq_req_o && seq_ack_i) begin
            seq_req_o <= 1'b0;
        end else if (commit) begin
            seq_req_o  <= 1'b1;
            seq_op_o   <= c_op;
            seq_addr_o <= c_addr;
            seq_data_o <= c_data;
        end
    end

    // R13: request and payload stay put until acknowledged
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req_o && !seq_ack_i |=> seq_req_o && $stable(seq_op_o) && $stable(seq_addr_o) && $stable(seq_data_o));

    // R13: request drops after the acknowledge
    p_req_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req_o && seq_ack_i |=> !seq_req_o);

    // R11: a request only appears from a frame in progress
    p_req_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_req_o) |-> $past(!cs_n_i));

    // R3: one memory strobe per byte, never back to back
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);
endmodule

// File: rtl/sflash_cmd_front.sv
// Module: top of the serial flash command front end; joins edge detection, receiver, decoder and output shifter.
// Assumes synchronised SCK, SI and chip select, with at least four clocks per SCK half period.
module sflash_cmd_front
    import sfc_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter int         SECTOR_LOG = 12,
    parameter logic [7:0] MFR_ID     = 8'hDA,
    parameter logic [7:0] DEV_ID     = 8'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              cs_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              seq_req_o,
    output logic [1:0]        seq_op_o,
    output logic [ADDR_W-1:0] seq_addr_o,
    output logic [7:0]        seq_data_o,
    input  logic              seq_ack_i,
    input  logic              seq_busy_i
);
    logic             rise;
    logic             fall;
    logic             byte_done;
    logic [7:0]       byte_val;
    logic [IDX_W-1:0] byte_idx;
    logic             load_req;
    logic [7:0]       nxt_byte;

    sfc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i),
        .rise(rise), .fall(fall)
    );

    sfc_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .rise(rise), .si_i(si_i),
        .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx)
    );

    sfc_decode #(
        .ADDR_W(ADDR_W), .SECTOR_LOG(SECTOR_LOG), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i),
        .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
        .mem_data_i(mem_data_i), .seq_ack_i(seq_ack_i), .seq_busy_i(seq_busy_i),
        .load_req(load_req), .nxt_byte(nxt_byte),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .seq_req_o(seq_req_o), .seq_op_o(seq_op_o),
        .seq_addr_o(seq_addr_o), .seq_data_o(seq_data_o)
    );

    sfc_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .fall(fall),
        .load_req(load_req), .nxt_byte(nxt_byte),
        .so_o(so_o), .so_oe_o(so_oe_o)
    );

    // R12: output is never enabled while the opcode byte is still arriving
    p_oe_after_opcode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe_o |-> byte_idx != IX_OPC);
endmodule

// File: tb/sflash_cmd_front_test.sv
module sflash_cmd_front_test;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        cs_n = 1'b1;
    logic        so_o, so_oe_o, mem_rd_o, seq_req_o;
    logic [16:0] mem_addr_o, seq_addr_o;
    logic [7:0]  mem_data = 8'h00;
    logic [1:0]  seq_op_o;
    logic [7:0]  seq_data_o;
    logic        seq_ack = 1'b0;
    logic        seq_busy = 1'b0;

    int checks = 0;
    int errors = 0;
    int n_req = 0;
    logic [1:0]  cap_op;
    logic [16:0] cap_addr;
    logic [7:0]  cap_data;

    always #2 clk = ~clk;

    sflash_cmd_front uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
        .so_o(so_o), .so_oe_o(so_oe_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_data_i(mem_data), .seq_req_o(seq_req_o), .seq_op_o(seq_op_o),
        .seq_addr_o(seq_addr_o), .seq_data_o(seq_data_o),
        .seq_ack_i(seq_ack), .seq_busy_i(seq_busy)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ {a[16:13], a[11:8]} ^ 8'h5A;
    endfunction

    // Memory model: data the clock after the strobe.
    always @(negedge clk) if (mem_rd_o) mem_data <= pat(mem_addr_o);

    // Sequencer model: acknowledge every request once and record it.
    always @(negedge clk) begin
        if (seq_req_o && !seq_ack) begin
            seq_ack  = 1'b1;
            cap_op   = seq_op_o;
            cap_addr = seq_addr_o;
            cap_data = seq_data_o;
            n_req++;
        end else begin
            seq_ack = 1'b0;
        end
    end

    // Per-clock model check: output never enabled outside chip select (R12).
    always @(negedge clk) begin
        if (rst_n && cs_n && so_oe_o) begin
            errors++;
            $display("FAIL R12 so_oe_o act 1 exp 0 while cs_n high");
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input string tag, input logic [7:0] tx, input logic exp_oe,
                        output logic [7:0] rx);
        logic oe_bad;
        oe_bad = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sck = 1'b0; si = tx[i];
            repeat (H-1) @(negedge clk);
            rx[i] = so_o;
            if (so_oe_o !== exp_oe) oe_bad = 1'b1;
            @(negedge clk); sck = 1'b1;
            repeat (H-1) @(negedge clk);
        end
        check({tag, " oe R12"}, {31'b0, oe_bad}, 32'd0);
    endtask

    task automatic part_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sck = 1'b0; si = 1'b1;
            repeat (H-1) @(negedge clk);
            @(negedge clk); sck = 1'b1;
            repeat (H-1) @(negedge clk);
        end
    endtask

    task automatic open_frame(input logic m3);
        @(negedge clk); sck = m3;
        repeat (3) @(negedge clk); cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic close_frame(input logic m3);
        repeat (H) @(negedge clk); sck = m3;
        repeat (H) @(negedge clk); cs_n = 1'b1;
        #1 check("R12 oe drop at cs rise", {31'b0, so_oe_o}, 32'd0);
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd_bytes(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3, input int nb);
        logic [7:0] rx;
        xfer(tag, b0, 1'b0, rx);
        if (nb > 1) xfer(tag, b1, 1'b0, rx);
        if (nb > 2) xfer(tag, b2, 1'b0, rx);
        if (nb > 3) xfer(tag, b3, 1'b0, rx);
    endtask

    task automatic read_run(input string tag, input logic m3, input logic [7:0] a2,
                            input logic [7:0] a1, input logic [7:0] a0, input int n,
                            input logic [16:0] start);
        logic [7:0] rx;
        open_frame(m3);
        cmd_bytes(tag, 8'hFF, a2, a1, a0, 4);
        xfer(tag, 8'h00, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            logic [16:0] ea;
            ea = start + 17'(k);
            xfer(tag, 8'h00, 1'b1, rx);
            check(tag, {24'b0, rx}, {24'b0, pat(ea)});
        end
        close_frame(m3);
    endtask

    initial begin
        logic [7:0] rx;
        int base;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 so_oe", {31'b0, so_oe_o}, 0);
        check("R1 mem_rd", {31'b0, mem_rd_o}, 0);
        check("R1 seq_req", {31'b0, seq_req_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2: mode 0 read, high address bits junk
        read_run("R2 read mode0", 1'b0, 8'hFE, 8'h01, 8'h23, 3, 17'h00123);
        // R2 and R3: mode 3 read across the top of the array
        read_run("R3 wrap mode3", 1'b1, 8'h01, 8'hFF, 8'hFE, 4, 17'h1FFFE);

        // R4: ID bytes for both select values
        open_frame(1'b0);
        cmd_bytes("R4 id", 8'h90, 8'h33, 8'h44, 8'h00, 4);
        xfer("R4 id", 8'h00, 1'b1, rx); check("R4 id A0=0", {24'b0, rx}, 32'hDA);
        xfer("R4 id", 8'h00, 1'b1, rx); check("R4 id repeat", {24'b0, rx}, 32'hDA);
        close_frame(1'b0);
        open_frame(1'b1);
        cmd_bytes("R4 id", 8'h90, 8'h00, 8'h00, 8'h01, 4);
        xfer("R4 id", 8'h00, 1'b1, rx); check("R4 id A0=1", {24'b0, rx}, 32'h98);
        close_frame(1'b1);

        // R5: status ready and busy
        open_frame(1'b0);
        cmd_bytes("R5 status", 8'h9F, 0, 0, 0, 1);
        xfer("R5 status", 8'h00, 1'b1, rx); check("R5 ready", {24'b0, rx}, 32'h01);
        xfer("R5 status", 8'h00, 1'b1, rx); check("R5 ready repeat", {24'b0, rx}, 32'h01);
        close_frame(1'b0);
        seq_busy = 1'b1;
        open_frame(1'b0);
        cmd_bytes("R5 status", 8'h9F, 0, 0, 0, 1);
        xfer("R5 status", 8'h00, 1'b1, rx); check("R5 busy", {24'b0, rx}, 32'h00);
        close_frame(1'b0);

        // R10: program and read ignored while busy
        base = n_req;
        open_frame(1'b0);
        cmd_bytes("R10 busy prog", 8'h10, 8'h00, 8'h12, 8'h34, 4);
        xfer("R10 busy prog", 8'h77, 1'b0, rx);
        close_frame(1'b0);
        check("R10 no request", n_req - base, 0);
        open_frame(1'b0);
        cmd_bytes("R10 busy read", 8'hFF, 8'h00, 8'h00, 8'h10, 4);
        xfer("R10 busy read", 8'h00, 1'b0, rx);
        xfer("R10 busy read", 8'h00, 1'b0, rx);
        close_frame(1'b0);
        seq_busy = 1'b0;

        // R8: byte program
        base = n_req;
        open_frame(1'b0);
        cmd_bytes("R8 prog", 8'h10, 8'hF0, 8'h45, 8'h67, 4);
        xfer("R8 prog", 8'h3C, 1'b0, rx);
        close_frame(1'b0);
        check("R8 one request", n_req - base, 1);
        check("R8 op", {30'b0, cap_op}, 32'd3);
        check("R8 addr", {15'b0, cap_addr}, 32'h04567);
        check("R8 data", {24'b0, cap_data}, 32'h3C);
        check("R13 req dropped", {31'b0, seq_req_o}, 0);

        // R6: sector erase
        base = n_req;
        open_frame(1'b1);
        cmd_bytes("R6 serase", 8'h20, 8'h03, 8'h5A, 8'hD0, 4);
        close_frame(1'b1);
        check("R6 one request", n_req - base, 1);
        check("R6 op", {30'b0, cap_op}, 32'd1);
        check("R6 addr", {15'b0, cap_addr}, 32'h15000);

        // R7: chip erase
        base = n_req;
        open_frame(1'b0);
        cmd_bytes("R7 cerase", 8'h60, 8'h11, 8'h22, 8'hD0, 4);
        close_frame(1'b0);
        check("R7 one request", n_req - base, 1);
        check("R7 op", {30'b0, cap_op}, 32'd2);
        check("R7 addr", {15'b0, cap_addr}, 32'h0);

        // R9: wrong confirm and unknown opcode
        base = n_req;
        open_frame(1'b0);
        cmd_bytes("R9 bad confirm", 8'h20, 8'h01, 8'h00, 8'hD1, 4);
        xfer("R9 bad confirm", 8'hD0, 1'b0, rx);
        close_frame(1'b0);
        open_frame(1'b0);
        cmd_bytes("R9 unknown", 8'h55, 8'h00, 8'h00, 8'hD0, 4);
        xfer("R9 unknown", 8'h00, 1'b0, rx);
        close_frame(1'b0);
        check("R9 no request", n_req - base, 0);

        // R11: program aborted mid data byte
        base = n_req;
        open_frame(1'b0);
        cmd_bytes("R11 abort", 8'h10, 8'h00, 8'h00, 8'h08, 4);
        part_bits(5);
        close_frame(1'b0);
        repeat (10) @(negedge clk);
        check("R11 no request", n_req - base, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule